// File: doc/BRIEF.md
# Iterative Integer Divider (signed and unsigned, quotient or remainder)

This block divides one 32-bit integer by another and returns either the quotient or the remainder. The operands can be treated as two's-complement signed values or as unsigned values. A two-bit operation code picks one of four result modes. A single restoring radix-2 core does the work in every mode. It runs on the operand magnitudes, one quotient bit per cycle, and the sign of the result is applied at the end. The result for division by zero is fixed, and so is the result for the one signed division whose quotient does not fit.

A request is a one-cycle `start` pulse, sampled while `busy` is low, with `op`, `dividend` and `divisor` valid in that same cycle. The request is accepted on that clock edge. `busy` stays high from the next cycle until the cycle in which `done` pulses. `done` is high for exactly one cycle, and `result` is valid in that cycle.

There is no back-pressure at the output. The block does not wait for the consumer. `result` keeps its value until the next `done` pulse, so it may also be read later. Control pins are plain strobes, not a valid/ready handshake.

Top module: `div_unit`

## Requirements
- R1: `op` = 2'b00 returns the signed quotient. It is rounded toward zero, for example -20 / 3 = -6.
- R2: `op` = 2'b10 returns the signed remainder. A nonzero remainder takes the sign of the dividend, for example -20 rem 3 = -2 and 20 rem -3 = 2.
- R3: `op` = 2'b01 returns the quotient with both operands read as unsigned.
- R4: `op` = 2'b11 returns the remainder with both operands read as unsigned.
- R5: A zero divisor gives all ones for a quotient and the unchanged dividend for a remainder. This holds in both signed and unsigned modes.
- R6: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: `done` is a single-cycle pulse. When the start pulse is accepted at clock edge E0, `done` is high in the cycle that follows edge E(W+1), which is E33 at the default width.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running request completes with its own result, and no extra `done` pulse follows.
- R9: Out of reset, `busy`, `done` and `result` are all zero.
- R10: `result` holds its value in every cycle in which `done` is low, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while `busy` is low |
| op | input | 2 | Operation: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| dividend | input | 32 | Dividend, sampled with an accepted `start` |
| divisor | input | 32 | Divisor, sampled with an accepted `start` |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 32 | Quotient or remainder of the last finished request |

## Verification
The bound checker captures each accepted request. On every cycle it checks the `done` pulse width, the exact latency from acceptance, that `result` holds between pulses, and that each result matches the arithmetic definition for the captured operands, including the zero-divisor and overflow cases. The bench scenarios show things a per-cycle property cannot: the values of the reset state, that a start pulse issued mid-run changes neither the result nor the number of `done` pulses, and hand-worked results for mixed-sign operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    OP_QUO_S = 2'b00,
    OP_QUO_U = 2'b01,
    OP_REM_S = 2'b10,
    OP_REM_U = 2'b11
  } div_op_e;

  // bit 0 of the code selects unsigned, bit 1 selects remainder
  function automatic logic op_is_signed(input logic [1:0] code);
    return ~code[0];
  endfunction

  function automatic logic op_is_rem(input logic [1:0] code);
    return code[1];
  endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         want_rem,
  output logic         by_zero
);
  import div_pkg::*;

  logic sgn;
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    sgn      = op_is_signed(op);
    dvd_neg  = sgn & dividend[W-1];
    dvs_neg  = sgn & divisor[W-1];
    dvd_mag  = dvd_neg ? (~dividend + 1'b1) : dividend;
    dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
    neg_quo  = dvd_neg ^ dvs_neg;
    neg_rem  = dvd_neg;
    want_rem = op_is_rem(op);
    by_zero  = (divisor == '0);
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic         running,
  output logic         finish,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;

  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          fits;

  // one restoring step: shift in the next dividend bit, try to subtract
  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~diff[W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load && !run_q) begin
        rem_q <= '0;
        quo_q <= dvd_mag;
        dvs_q <= dvs_mag;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W:0] : shifted;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign running = run_q;
  assign finish  = fin_q;
  assign quo     = quo_q;
  assign rem     = rem_q[W-1:0];
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         want_rem,
  input  logic         by_zero,
  output logic [W-1:0] value
);
  logic [W-1:0] q_signed;
  logic [W-1:0] r_signed;

  always_comb begin
    q_signed = neg_quo ? (~quo + 1'b1) : quo;
    r_signed = neg_rem ? (~rem + 1'b1) : rem;
    if (want_rem)
      value = r_signed;
    else if (by_zero)
      value = '1;
    else
      value = q_signed;
  end
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0] dvd_mag, dvs_mag;
  logic         p_neg_quo, p_neg_rem, p_want_rem, p_by_zero;
  logic         neg_quo_q, neg_rem_q, want_rem_q, by_zero_q;
  logic         core_run, core_fin;
  logic [W-1:0] core_quo, core_rem;
  logic [W-1:0] fixed;
  logic         accept;
  logic         done_q;
  logic [W-1:0] result_q;

  assign busy   = core_run | core_fin;
  assign accept = start & ~busy;

  div_prep #(.W(W)) u_prep (
    .op       (op),
    .dividend (dividend),
    .divisor  (divisor),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .neg_quo  (p_neg_quo),
    .neg_rem  (p_neg_rem),
    .want_rem (p_want_rem),
    .by_zero  (p_by_zero)
  );

  div_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .running (core_run),
    .finish  (core_fin),
    .quo     (core_quo),
    .rem     (core_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      want_rem_q <= 1'b0;
      by_zero_q  <= 1'b0;
    end else if (accept) begin
      neg_quo_q  <= p_neg_quo;
      neg_rem_q  <= p_neg_rem;
      want_rem_q <= p_want_rem;
      by_zero_q  <= p_by_zero;
    end
  end

  div_fix #(.W(W)) u_fix (
    .quo      (core_quo),
    .rem      (core_rem),
    .neg_quo  (neg_quo_q),
    .neg_rem  (neg_rem_q),
    .want_rem (want_rem_q),
    .by_zero  (by_zero_q),
    .value    (fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= core_fin;
      if (core_fin) result_q <= fixed;
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int CW = $clog2(W) + 3;
  localparam logic [CW-1:0] LAT = CW'(W + 2);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] since_q;
  logic [1:0]    c_op;
  logic [W-1:0]  c_dvd, c_dvs;
  logic          seen_q;
  logic [W-1:0]  exp_v;
  logic          ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      c_op    <= '0;
      c_dvd   <= '0;
      c_dvs   <= '0;
      seen_q  <= 1'b0;
    end else if (start && !busy) begin
      since_q <= CW'(1);
      c_op    <= op;
      c_dvd   <= dividend;
      c_dvs   <= divisor;
      seen_q  <= 1'b1;
    end else if (since_q != '0 && since_q < LAT + 1'b1) begin
      since_q <= since_q + 1'b1;
    end
  end

  always_comb begin
    ovf = (c_dvd == MINV) && (c_dvs == '1);
    if (c_dvs == '0)
      exp_v = c_op[1] ? c_dvd : '1;
    else if (!c_op[0] && ovf)
      exp_v = c_op[1] ? '0 : MINV;
    else begin
      case (c_op)
        2'b00:   exp_v = W'($signed(c_dvd) / $signed(c_dvs));
        2'b10:   exp_v = W'($signed(c_dvd) % $signed(c_dvs));
        2'b01:   exp_v = c_dvd / c_dvs;
        default: exp_v = c_dvd % c_dvs;
      endcase
    end
  end

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done arrives exactly W+1 edges after the accepting edge
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen_q && since_q == LAT));

  // R10: result only moves together with done
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R1 R2 R3 R4: arithmetic value of a normal request
  p_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_dvs != '0 && !(ovf && !c_op[0])) |-> result == exp_v);

  // R5: zero divisor
  p_by_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_dvs == '0) |-> result == (c_op[1] ? c_dvd : '1));

  // R6: signed overflow
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !c_op[0] && ovf) |-> result == (c_op[1] ? '0 : MINV));

  // R8: no second request can be accepted while busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done));
endmodule

bind div_unit div_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .dividend (dividend),
  .divisor  (divisor),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/tb_div_unit.sv
`timescale 1ns/1ps
module tb_div_unit;
  localparam int W  = 32;
  localparam int NV = 22;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = '0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  div_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
  );

  // {op, dividend, divisor, expected}
  localparam logic [97:0] VEC [NV] = '{
    {2'b00, 32'd20,         32'd3,          32'd6},
    {2'b00, 32'hFFFFFFEC,   32'd3,          32'hFFFFFFFA},
    {2'b00, 32'd20,         32'hFFFFFFFD,   32'hFFFFFFFA},
    {2'b00, 32'hFFFFFFEC,   32'hFFFFFFFD,   32'd6},
    {2'b00, 32'd7,          32'd9,          32'd0},
    {2'b10, 32'hFFFFFFEC,   32'd3,          32'hFFFFFFFE},
    {2'b10, 32'd20,         32'hFFFFFFFD,   32'd2},
    {2'b10, 32'hFFFFFFF9,   32'd9,          32'hFFFFFFF9},
    {2'b01, 32'hFFFFFFEC,   32'd3,          32'h5555554E},
    {2'b01, 32'd100,        32'd7,          32'd14},
    {2'b01, 32'h80000000,   32'hFFFFFFFF,   32'd0},
    {2'b11, 32'hFFFFFFEC,   32'd3,          32'd2},
    {2'b11, 32'd100,        32'd7,          32'd2},
    {2'b11, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
    {2'b00, 32'd5,          32'd0,          32'hFFFFFFFF},
    {2'b01, 32'd7,          32'd0,          32'hFFFFFFFF},
    {2'b10, 32'hFFFFFFEC,   32'd0,          32'hFFFFFFEC},
    {2'b11, 32'd7,          32'd0,          32'd7},
    {2'b00, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
    {2'b10, 32'h80000000,   32'hFFFFFFFF,   32'd0},
    {2'b00, 32'h80000000,   32'd0,          32'hFFFFFFFF},
    {2'b10, 32'h80000000,   32'd0,          32'h80000000}
  };

  function automatic string tag_of(input logic [1:0] o, input logic [W-1:0] a,
                                   input logic [W-1:0] b);
    if (b == '0) return "R5";
    if (!o[0] && a == 32'h80000000 && b == '1) return "R6";
    case (o)
      2'b00:   return "R1";
      2'b10:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue a request, wait for done, check value, latency and pulse width
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] exp);
    int k;
    while (busy) @(negedge clk);
    op = o; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(tag_of(o, a, b), result, exp);
    check("R7 latency", W'(k), W'(W + 2));
    @(negedge clk);
    check("R7 pulse", W'(done), '0);
  endtask

  initial begin
    #(5 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    int extra;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", W'(busy), '0);
    check("R9 done", W'(done), '0);
    check("R9 result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

    // R8: start while busy is ignored
    op = 2'b01; dividend = 32'd1000; divisor = 32'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'b11; dividend = 32'd55; divisor = 32'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R8 first result", result, 32'd100);
    extra = 0;
    for (int c = 0; c < 3 * W; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R8 extra done", W'(extra), '0);

    // R10: result holds while inputs move and no request is made
    held = result;
    op = 2'b00; dividend = 32'hDEADBEEF; divisor = 32'd3;
    repeat (10) @(negedge clk);
    check("R10 hold", result, held);
    check("R10 idle", W'(busy), '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule